// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns incoming message-signalled interrupt writes into entries of a circular event queue kept in system memory. Every accepted message becomes one 16-byte entry whose first little-endian word carries a 16-bit interrupt number. The entry is written through a single-beat valid/ready write master to the queue base address plus the current write offset. The block then raises a level interrupt for as long as software has entries left to consume.

Software sets the block up through a small word-addressed register port. The port holds a control word, the queue base address split into two 32-bit halves, and the read and write offsets. Software drains entries starting at its read offset, advances that offset by 16 per entry, and writes it back. The write offset counter does not wrap at the queue size, so software masks it before comparing.

A size code picks a queue length of 32, 64, 128 or 256 KiB. When the queue fills, full detection either stalls incoming messages or drops them and records a sticky overflow flag.

Top module: `msi_queue_writer`

## Requirements
- R1: After reset every register reads zero, and irq_o, mem_valid_o and msg_ready_o are low.
- R2: Register word offsets are control 0, base high 3, base low 4, read offset 5, write offset 6. Control bits are: 0 enable, 1 full detection, 3 interrupt enable, 4 stop-on-full, 9:8 size code, 31 overflow. All other control bits read as zero.
- R3: An entry is written at the address {base high, base low} plus (write offset AND mask), where mask = (2^(15+code) − 1) with bits 3:0 cleared.
- R4: mem_data_o bits 15:0 carry msg_data_i bits 15:0, and the other 112 bits of the entry are zero.
- R5: Only one write is outstanding at a time. msg_ready_o stays low while mem_valid_o is high, and address and data hold steady until mem_ready_i.
- R6: The write offset register advances by 16 in the cycle the memory handshake completes, and not when the message is accepted.
- R7: irq_o is high exactly when enable and interrupt enable are set and the masked read offset differs from the masked write offset.
- R8: The queue is full when ((masked write offset + 16) AND mask) equals the masked read offset. With full detection and stop-on-full set, msg_ready_o is low while the queue is full.
- R9: With full detection set and stop-on-full clear, a message arriving while the queue is full is accepted and discarded. No memory write occurs, the write offset is unchanged and control bit 31 is set. Writing control with bit 31 = 1 clears that bit.
- R10: With full detection clear, messages are written even when the queue is full.
- R11: With enable clear, msg_ready_o and irq_o are low, and the base and offset registers keep their values.
- R12: The write offset counts past the queue size without wrapping, while addresses wrap to the base. With code 0, an entry at offset 0x7FF0 leaves the register at 0x8000, and the next entry goes to base + 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| msg_valid_i | input | 1 | Incoming message valid |
| msg_ready_o | output | 1 | Block can accept a message |
| msg_data_i | input | 32 | Message payload; bits 15:0 are the interrupt number |
| mem_valid_o | output | 1 | Memory write request valid |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 64 | Byte address of the entry |
| mem_data_o | output | 128 | Entry contents, byte 0 in bits 7:0 |
| irq_o | output | 1 | Unread entries pending |

## Verification
The main write path is driven by a sequence of messages that crosses the end of a 32 KiB queue. This separates a correctly masked address from one built on the raw counter, and it shows whether the raw register kept counting past the size. Payloads with all ones or with junk in the upper half test that only the low 16 bits reach the entry. A full queue is presented three ways: stalled, dropped with overflow, and full detection off. These tell back-pressure, drop and overwrite apart. A misaligned, out-of-range offset under the largest size code checks the mask for both the size and the alignment.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam logic [2:0] REG_CTRL    = 3'd0;
  localparam logic [2:0] REG_BASE_HI = 3'd3;
  localparam logic [2:0] REG_BASE_LO = 3'd4;
  localparam logic [2:0] REG_RD_OFF  = 3'd5;
  localparam logic [2:0] REG_WR_OFF  = 3'd6;

  localparam int BIT_EN       = 0;
  localparam int BIT_FULL_DET = 1;
  localparam int BIT_IRQ_EN   = 3;
  localparam int BIT_STOP     = 4;
  localparam int BIT_SIZE_LO  = 8;
  localparam int BIT_OVF      = 31;

  typedef struct packed {
    logic       ovf;
    logic [1:0] size;
    logic       stop;
    logic       irq_en;
    logic       full_det;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/msiq_regs.sv
module msiq_regs
  import msiq_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 32,
  parameter int STEP   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              adv_i,
  input  logic              ovf_set_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic [OFF_W-1:0]  wr_off_o
);
  localparam int HALF_W = ADDR_W / 2;

  ctrl_t             ctrl_q;
  logic [HALF_W-1:0] base_hi_q, base_lo_q;
  logic [OFF_W-1:0]  rd_q, wr_q;

  logic wr_ctrl, wr_hi, wr_lo, wr_rd, wr_wr;
  assign wr_ctrl = reg_wr_i && reg_addr_i == REG_CTRL;
  assign wr_hi   = reg_wr_i && reg_addr_i == REG_BASE_HI;
  assign wr_lo   = reg_wr_i && reg_addr_i == REG_BASE_LO;
  assign wr_rd   = reg_wr_i && reg_addr_i == REG_RD_OFF;
  assign wr_wr   = reg_wr_i && reg_addr_i == REG_WR_OFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en       <= reg_wdata_i[BIT_EN];
        ctrl_q.full_det <= reg_wdata_i[BIT_FULL_DET];
        ctrl_q.irq_en   <= reg_wdata_i[BIT_IRQ_EN];
        ctrl_q.stop     <= reg_wdata_i[BIT_STOP];
        ctrl_q.size     <= reg_wdata_i[BIT_SIZE_LO +: 2];
      end
      // sticky overflow: hardware set wins over write-1-to-clear
      if (ovf_set_i)                            ctrl_q.ovf <= 1'b1;
      else if (wr_ctrl && reg_wdata_i[BIT_OVF]) ctrl_q.ovf <= 1'b0;
      if (wr_hi) base_hi_q <= reg_wdata_i[HALF_W-1:0];
      if (wr_lo) base_lo_q <= reg_wdata_i[HALF_W-1:0];
      if (wr_rd) rd_q <= reg_wdata_i[OFF_W-1:0];
      // software write takes priority over hardware advance
      if (wr_wr)      wr_q <= reg_wdata_i[OFF_W-1:0];
      else if (adv_i) wr_q <= wr_q + OFF_W'(STEP);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[BIT_EN]            = ctrl_q.en;
        reg_rdata_o[BIT_FULL_DET]      = ctrl_q.full_det;
        reg_rdata_o[BIT_IRQ_EN]        = ctrl_q.irq_en;
        reg_rdata_o[BIT_STOP]          = ctrl_q.stop;
        reg_rdata_o[BIT_SIZE_LO +: 2]  = ctrl_q.size;
        reg_rdata_o[BIT_OVF]           = ctrl_q.ovf;
      end
      REG_BASE_HI: reg_rdata_o[HALF_W-1:0] = base_hi_q;
      REG_BASE_LO: reg_rdata_o[HALF_W-1:0] = base_lo_q;
      REG_RD_OFF:  reg_rdata_o[OFF_W-1:0]  = rd_q;
      REG_WR_OFF:  reg_rdata_o[OFF_W-1:0]  = wr_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign base_o   = {base_hi_q, base_lo_q};
  assign rd_off_o = rd_q;
  assign wr_off_o = wr_q;
endmodule

// File: rtl/msiq_offset.sv
module msiq_offset #(
  parameter int OFF_W      = 32,
  parameter int SIZE_CODES = 4,
  parameter int MIN_SHIFT  = 15,
  parameter int STEP       = 16,
  localparam int CODE_W    = $clog2(SIZE_CODES)
) (
  input  logic [CODE_W-1:0] size_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  output logic [OFF_W-1:0]  wr_m_o,
  output logic              pending_o,
  output logic              full_o
);
  logic [OFF_W-1:0] mask_tbl [SIZE_CODES];
  logic [OFF_W-1:0] mask, rd_m, nxt_m;

  for (genvar g = 0; g < SIZE_CODES; g++) begin : g_mask
    assign mask_tbl[g] = ((OFF_W'(1) << (MIN_SHIFT + g)) - OFF_W'(1))
                         & ~OFF_W'(STEP - 1);
  end

  assign mask      = mask_tbl[size_i];
  assign wr_m_o    = wr_off_i & mask;
  assign rd_m      = rd_off_i & mask;
  assign nxt_m     = (wr_m_o + OFF_W'(STEP)) & mask;
  assign pending_o = rd_m != wr_m_o;
  assign full_o    = nxt_m == rd_m;
endmodule

// File: rtl/msiq_writer.sv
module msiq_writer #(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 32,
  parameter int MSG_W   = 32,
  parameter int IRQ_W   = 16,
  parameter int ENTRY_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               block_i,
  input  logic               drop_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [OFF_W-1:0]   wr_m_i,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic [MSG_W-1:0]   msg_data_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  output logic               adv_o,
  output logic               ovf_set_o
);
  logic               busy_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ENTRY_W-1:0] data_q;
  logic               accept;
  logic               unused_hi;

  assign unused_hi   = ^msg_data_i[MSG_W-1:IRQ_W];
  assign msg_ready_o = en_i && !busy_q && !block_i;
  assign accept      = msg_valid_i && msg_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept && !drop_i) begin
      busy_q <= 1'b1;
      addr_q <= base_i + ADDR_W'(wr_m_i);
      data_q <= ENTRY_W'(msg_data_i[IRQ_W-1:0]);
    end else if (busy_q && mem_ready_i) begin
      busy_q <= 1'b0;
    end
  end

  assign mem_valid_o = busy_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = data_q;
  assign adv_o       = busy_q && mem_ready_i;
  assign ovf_set_o   = accept && drop_i;
endmodule

// File: rtl/msi_queue_writer.sv
module msi_queue_writer
  import msiq_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int MSG_W      = 32,
  parameter int IRQ_W      = 16,
  parameter int ENTRY_B    = 16,
  parameter int SIZE_CODES = 4,
  parameter int MIN_SHIFT  = 15,
  localparam int ENTRY_W   = ENTRY_B * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic [MSG_W-1:0]   msg_data_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [ENTRY_W-1:0] mem_data_o,
  output logic               irq_o
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  rd_off, wr_off, wr_m;
  logic              adv, ovf_set, pending, full;
  logic              ctrl_en, ctrl_irq_en, full_hit;

  assign ctrl_en     = ctrl.en;
  assign ctrl_irq_en = ctrl.irq_en;
  assign full_hit    = full && ctrl.full_det;

  msiq_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP(ENTRY_B)
  ) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .adv_i(adv), .ovf_set_i(ovf_set), .ctrl_o(ctrl), .base_o(base),
    .rd_off_o(rd_off), .wr_off_o(wr_off)
  );

  msiq_offset #(
    .OFF_W(OFF_W), .SIZE_CODES(SIZE_CODES), .MIN_SHIFT(MIN_SHIFT), .STEP(ENTRY_B)
  ) u_off (
    .size_i(ctrl.size), .rd_off_i(rd_off), .wr_off_i(wr_off),
    .wr_m_o(wr_m), .pending_o(pending), .full_o(full)
  );

  msiq_writer #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MSG_W(MSG_W), .IRQ_W(IRQ_W), .ENTRY_W(ENTRY_W)
  ) u_wr (
    .clk_i, .rst_ni, .en_i(ctrl_en),
    .block_i(full_hit && ctrl.stop), .drop_i(full_hit && !ctrl.stop),
    .base_i(base), .wr_m_i(wr_m),
    .msg_valid_i, .msg_ready_o, .msg_data_i,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_data_o,
    .adv_o(adv), .ovf_set_o(ovf_set)
  );

  assign irq_o = ctrl_en && ctrl_irq_en && pending;
endmodule

// File: rtl/msiq_checker.sv
module msiq_checker #(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 32,
  parameter int ENTRY_W = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_ready_i,
  input logic               mem_valid_i,
  input logic               mem_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_i,
  input logic [ENTRY_W-1:0] mem_data_i,
  input logic               irq_i,
  input logic               en_i,
  input logic               irq_en_i,
  input logic [OFF_W-1:0]   wr_off_i,
  input logic               reg_wr_i,
  input logic [2:0]         reg_addr_i
);
  // R5
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_ready_i && mem_valid_i));

  // R5
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && !mem_ready_i |=> mem_valid_i && $stable(mem_addr_i) && $stable(mem_data_i));

  // R4
  entry_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i |-> mem_data_i[ENTRY_W-1:16] == '0);

  // R6
  wr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_i && mem_ready_i && !(reg_wr_i && reg_addr_i == 3'd6)
    |=> wr_off_i == $past(wr_off_i) + OFF_W'(16));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> en_i && irq_en_i);

  // R11
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !msg_ready_i && !irq_i);
endmodule

bind msi_queue_writer msiq_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_ready_i(msg_ready_o),
  .mem_valid_i(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_i(mem_addr_o), .mem_data_i(mem_data_o), .irq_i(irq_o),
  .en_i(ctrl_en), .irq_en_i(ctrl_irq_en), .wr_off_i(wr_off),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i)
);

// File: tb/tb_msi_queue_writer.sv
module tb_msi_queue_writer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         msg_valid, msg_ready;
  logic [31:0]  msg_data;
  logic         mem_valid, mem_ready;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [63:0] BASE = 64'h0000_00AB_CD00_0000;
  localparam int NV = 4;
  localparam logic [31:0] VEC_MSG [NV] = '{32'h1234_0005, 32'h0000_FFFF, 32'hDEAD_0001, 32'h0000_0042};
  localparam logic [31:0] VEC_OFF [NV] = '{32'h7FD0, 32'h7FE0, 32'h7FF0, 32'h0000};
  localparam logic [31:0] VEC_WR  [NV] = '{32'h7FE0, 32'h7FF0, 32'h8000, 32'h8010};

  always #2.5 clk = ~clk;

  msi_queue_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msg_valid_i(msg_valid), .msg_ready_o(msg_ready), .msg_data_i(msg_data),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d);
    msg_data = d; msg_valid = 1'b1;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic complete();
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_valid = 1'b0; msg_data = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 msg_ready", msg_ready, 0);
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), rd);
      chk("R1 reg", rd, 0);
    end

    // R2 field positions and reserved bits
    wreg(3'd0, 32'h0000_01FF);
    rreg(3'd0, rd); chk("R2 ctrl", rd, 32'h0000_011B);
    wreg(3'd3, BASE[63:32]);
    wreg(3'd4, BASE[31:0]);
    rreg(3'd3, rd); chk("R2 base_hi", rd, BASE[63:32]);
    rreg(3'd4, rd); chk("R2 base_lo", rd, BASE[31:0]);

    // table walk across the 32 KiB boundary: R3 R4 R5 R6 R12
    wreg(3'd6, 32'h7FD0);
    wreg(3'd5, 32'h7FD0);
    wreg(3'd0, 32'h0000_001B);
    chk("R7 equal offsets", irq, 0);
    for (int i = 0; i < NV; i++) begin
      push(VEC_MSG[i]);
      chk("R5 mem_valid", mem_valid, 1);
      chk("R3 R12 addr", mem_addr, BASE + 64'(VEC_OFF[i]));
      chk("R4 data", mem_data, 128'(VEC_MSG[i][15:0]));
      chk("R5 ready low while busy", msg_ready, 0);
      rreg(3'd6, rd);
      chk("R6 no advance on accept", rd, (i == 0) ? 32'h7FD0 : VEC_WR[i-1]);
      @(negedge clk);
      chk("R5 hold addr", mem_addr, BASE + 64'(VEC_OFF[i]));
      complete();
      chk("R5 released", mem_valid, 0);
      rreg(3'd6, rd);
      chk("R6 R12 wr_off", rd, VEC_WR[i]);
    end
    chk("R7 pending", irq, 1);

    // R8 stall on full
    wreg(3'd6, 32'h30);
    wreg(3'd5, 32'h40);
    wreg(3'd0, 32'h0000_001B);
    msg_data = 32'h0000_0099; msg_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R8 ready low when full", msg_ready, 0);
      @(negedge clk);
    end
    msg_valid = 1'b0;
    chk("R8 no write", mem_valid, 0);

    // R9 drop with overflow
    wreg(3'd0, 32'h0000_000B);
    push(32'h0000_0077);
    chk("R9 no write", mem_valid, 0);
    rreg(3'd6, rd); chk("R9 wr_off unchanged", rd, 32'h30);
    rreg(3'd0, rd); chk("R9 ovf set", rd, 32'h8000_000B);
    wreg(3'd0, 32'h8000_000B);
    rreg(3'd0, rd); chk("R9 ovf cleared", rd, 32'h0000_000B);

    // R10 overwrite with full detection off
    wreg(3'd0, 32'h0000_0009);
    push(32'h0000_0055);
    chk("R10 write", mem_valid, 1);
    chk("R10 addr", mem_addr, BASE + 64'h30);
    complete();
    rreg(3'd6, rd); chk("R10 wr_off", rd, 32'h40);
    chk("R7 caught up", irq, 0);

    // R11 disable
    wreg(3'd5, 32'h100);
    chk("R7 pending", irq, 1);
    wreg(3'd0, 32'h0);
    msg_valid = 1'b1;
    @(negedge clk);
    chk("R11 ready", msg_ready, 0);
    chk("R11 irq", irq, 0);
    msg_valid = 1'b0;
    rreg(3'd4, rd); chk("R11 base kept", rd, BASE[31:0]);
    rreg(3'd6, rd); chk("R11 wr_off kept", rd, 32'h40);
    rreg(3'd5, rd); chk("R11 rd_off kept", rd, 32'h100);

    // R3 largest size code, misaligned out-of-range offset
    wreg(3'd6, 32'h0004_0027);
    wreg(3'd5, 32'h0);
    wreg(3'd0, 32'h0000_0309);
    push(32'hBEEF_1234);
    chk("R3 addr code3", mem_addr, BASE + 64'h20);
    chk("R4 data code3", mem_data, 128'h1234);
    complete();
    rreg(3'd6, rd); chk("R6 raw advance", rd, 32'h0004_0037);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule